// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block controls a multiplexed 8-input data acquisition converter with a 12-bit parallel result bus. After a scan is launched, it selects each enabled channel on a 3-bit address in turn. It waits until both the acquisition interval and the minimum sample period for the chosen gain have expired. It then fires a start-convert pulse and follows the converter's busy flag until the conversion finishes.

Once the busy flag falls, the sequencer pulls the active-low bus enable down for a short window and latches the word. If the converter is strapped for complementary coding, the word is inverted back to straight or offset binary. The result goes out with its channel number on a valid/ready stream. A full stream stalls the scan. A conversion that never finishes is abandoned with a one-cycle error pulse.

Top module: `adc_scan_seq`

## Requirements
- R1: Out of reset, `adc_start`, `s_valid` and `err_timeout` are low, `adc_oe_n` is high and `adc_addr` is 0.
- R2: A scan visits the enabled channels in ascending order, and each sample's `s_chan` equals the address used for that conversion. With `diff_mode` high, mask bits 7..4 are ignored, so only addresses 0..3 are used.
- R3: Every start pulse stays high for exactly START_W cycles (10 cycles at 100 MHz with the default 100 ns).
- R4: `gain_sel` codes 0..5 stand for gains 1, 2, 4, 8, 10 and 100, with minimum periods of ceil(CLK_HZ/rate) for rates of 400, 325, 275, 225, 175 and 40 kHz. Codes 6 and 7 use the 40 kHz entry. When conversion, capture and acquisition are shorter than that period, consecutive start rising edges are exactly one period apart (250, 308, 364, 445, 572 and 2500 cycles at 100 MHz).
- R5: `adc_oe_n` goes low only after the busy flag has fallen, stays low for OE_CYC cycles (2 by default) per conversion, and is high at all other times.
- R6: With `comp_code` high, `s_data` is the bitwise inverse of the bus word. With it low, `s_data` equals the bus word. Bus bit 11 is the MSB.
- R7: `adc_addr` changes only after the previous capture (or at scan launch), never between a start pulse and its capture.
- R8: While `s_valid` is high and `s_ready` is low, `s_data` and `s_chan` hold steady and no new start pulse is issued.
- R9: A rising edge on `run` launches a scan. With `single` high, the scan ends after one pass. With it low, the scan wraps to the lowest enabled channel until `run` is low.
- R10: If the busy flag has not fallen within TMO_CYC cycles (100 by default, i.e. 1 us) of the start rising edge, `err_timeout` pulses for one cycle, no sample is produced, and the scan moves to the next channel.
- R11: With no enabled channel (after the differential restriction), a launch issues no conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Scan launch (rising edge), continuous-mode keep-alive (level) |
| single | input | 1 | 1: one pass, 0: continuous wrap |
| ch_mask | input | 8 | Channel enable mask, bit i enables address i |
| gain_sel | input | 3 | Gain code selecting the minimum sample period |
| diff_mode | input | 1 | Differential pairing: only addresses 0..3 |
| comp_code | input | 1 | Converter emits complementary coding |
| adc_addr | output | 3 | Multiplexer address to the converter |
| adc_start | output | 1 | Start-convert pulse |
| adc_eoc | input | 1 | Converter busy flag, high during conversion |
| adc_oe_n | output | 1 | Active-low bus output enable |
| adc_bus | input | 12 | Parallel result bus, bit 11 is MSB |
| err_timeout | output | 1 | One-cycle conversion timeout pulse |
| s_valid | output | 1 | Sample stream valid |
| s_ready | input | 1 | Sample stream ready |
| s_data | output | 12 | Sample in straight/offset binary |
| s_chan | output | 3 | Channel tag of the sample |

## Verification
The hardest condition to reach is a stalled stream that lasts longer than a whole sample period. Only then would a careless design either fire the next start pulse or let the held sample drift. The bench holds `s_ready` low through several gain periods with a second channel pending, then confirms the held word, the absence of new start pulses and the later in-order delivery. The timeout path needs a converter that stays busy. The bench's converter stub has a programmable conversion length, which is stretched past the bound so that two consecutive channels both expire.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_PULSE,
    ST_CONV,
    ST_CAPT,
    ST_PUSH,
    ST_ADV
  } seq_st_e;

  localparam int unsigned NGAIN = 6;

  // throughput per gain code, slowest entry for out-of-range codes
  function automatic int unsigned gain_rate_hz(input int unsigned g);
    case (g)
      0:       return 400000;
      1:       return 325000;
      2:       return 275000;
      3:       return 225000;
      4:       return 175000;
      default: return 40000;
    endcase
  endfunction

  function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
    return (a + b - 1) / b;
  endfunction

endpackage

// File: rtl/adcseq_sync.sv
module adcseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= d;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/adcseq_chan_pick.sv
module adcseq_chan_pick #(
  parameter int CHN = 8,
  localparam int AW = $clog2(CHN)
) (
  input  logic [CHN-1:0] mask,
  input  logic           diff_mode,
  input  logic [AW-1:0]  cur,
  output logic [AW-1:0]  first_ch,
  output logic           first_ok,
  output logic [AW-1:0]  next_ch,
  output logic           next_ok
);
  localparam int HALF = CHN / 2;

  logic [CHN-1:0] emask;
  logic [CHN-1:0] above;

  generate
    for (genvar i = 0; i < CHN; i++) begin : g_ch
      if (i < HALF) begin : g_low
        assign emask[i] = mask[i];
      end else begin : g_high
        assign emask[i] = mask[i] & ~diff_mode;
      end
      assign above[i] = emask[i] & (AW'(i) > cur);
    end
  endgenerate

  // lowest set bit wins: scan from the top so the last hit is the lowest
  always_comb begin
    first_ch = '0;
    next_ch  = '0;
    for (int i = CHN - 1; i >= 0; i--) begin
      if (emask[i]) first_ch = AW'(i);
      if (above[i]) next_ch  = AW'(i);
    end
    first_ok = |emask;
    next_ok  = |above;
  end
endmodule

// File: rtl/adcseq_pacer.sv
module adcseq_pacer
  import adcseq_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_evt,
  input  logic [2:0] gain_sel,
  output logic       period_ok
);
  localparam int unsigned PMAX = ceil_div(CLK_HZ, 40000);
  localparam int PW = $clog2(PMAX + 1);

  logic [PW-1:0] per_tab [NGAIN];
  logic [PW-1:0] limit;
  logic [PW-1:0] pcnt, pcnt_nx;
  logic [2:0]    gidx;

  generate
    for (genvar g = 0; g < NGAIN; g++) begin : g_tab
      assign per_tab[g] = PW'(ceil_div(CLK_HZ, gain_rate_hz(g)));
    end
  endgenerate

  always_comb begin
    gidx = (gain_sel > 3'd5) ? 3'd5 : gain_sel;
    limit = per_tab[gidx];
    period_ok = (pcnt >= limit - PW'(1));
    if (start_evt)                pcnt_nx = '0;
    else if (pcnt == PW'(PMAX))   pcnt_nx = pcnt;
    else                          pcnt_nx = pcnt + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pcnt <= PW'(PMAX);
    else        pcnt <= pcnt_nx;

  // R4: a start is only ever requested once the period has run out
  assert_period_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> period_ok);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adcseq_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int          CHN      = 8,
  parameter int          DW       = 12,
  parameter int unsigned START_NS = 100,
  parameter int unsigned TMO_NS   = 1000,
  parameter int          ACQ_CYC  = 40,
  parameter int          OE_CYC   = 2,
  parameter int          SYNC_STG = 2,
  localparam int         AW       = $clog2(CHN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          single,
  input  logic [CHN-1:0] ch_mask,
  input  logic [2:0]    gain_sel,
  input  logic          diff_mode,
  input  logic          comp_code,
  output logic [AW-1:0] adc_addr,
  output logic          adc_start,
  input  logic          adc_eoc,
  output logic          adc_oe_n,
  input  logic [DW-1:0] adc_bus,
  output logic          err_timeout,
  output logic          s_valid,
  input  logic          s_ready,
  output logic [DW-1:0] s_data,
  output logic [AW-1:0] s_chan
);
  localparam int unsigned SW_RAW  = (CLK_HZ / 1000) * START_NS / 1_000_000;
  localparam int unsigned START_W = (SW_RAW < 1) ? 1 : SW_RAW;
  localparam int unsigned TMO_CYC = (CLK_HZ / 1000) * TMO_NS / 1_000_000;
  localparam int TW  = $clog2(TMO_CYC + 1);
  localparam int QW  = $clog2(ACQ_CYC + 1);
  localparam int OW  = $clog2(OE_CYC + 1);
  localparam logic [TW-1:0] SW_LAST  = TW'(START_W - 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYC - 1);
  localparam logic [QW-1:0] AQ_LAST  = QW'(ACQ_CYC - 1);
  localparam logic [OW-1:0] OE_LAST  = OW'(OE_CYC - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rs <= 2'b00;
    else        rs <= {rs[0], 1'b1};
  assign rst_i = rs[1];

  seq_st_e       st, st_nx;
  logic [AW-1:0] addr_nx;
  logic          scan_single, single_nx;
  logic          run_q;
  logic [QW-1:0] acnt, acnt_nx;
  logic [TW-1:0] tcnt, tcnt_nx;
  logic [OW-1:0] ocnt, ocnt_nx;
  logic          seen, seen_nx;
  logic          err_nx, cap_en, start_evt;
  logic          eoc_s, period_ok;
  logic [AW-1:0] first_ch, next_ch;
  logic          first_ok, next_ok;
  logic [DW-1:0] cap_word;

  adcseq_sync #(.STAGES(SYNC_STG)) u_eoc_sync (
    .clk(clk), .rst_n(rst_i), .d(adc_eoc), .q(eoc_s)
  );

  adcseq_chan_pick #(.CHN(CHN)) u_pick (
    .mask(ch_mask), .diff_mode(diff_mode), .cur(adc_addr),
    .first_ch(first_ch), .first_ok(first_ok),
    .next_ch(next_ch), .next_ok(next_ok)
  );

  adcseq_pacer #(.CLK_HZ(CLK_HZ)) u_pacer (
    .clk(clk), .rst_n(rst_i), .start_evt(start_evt),
    .gain_sel(gain_sel), .period_ok(period_ok)
  );

  assign cap_word = comp_code ? ~adc_bus : adc_bus;

  always_comb begin
    st_nx     = st;
    addr_nx   = adc_addr;
    single_nx = scan_single;
    acnt_nx   = acnt;
    tcnt_nx   = tcnt;
    ocnt_nx   = ocnt;
    seen_nx   = seen;
    err_nx    = 1'b0;
    cap_en    = 1'b0;
    start_evt = 1'b0;
    case (st)
      ST_IDLE: begin
        if (run && !run_q && first_ok) begin
          addr_nx   = first_ch;
          single_nx = single;
          acnt_nx   = '0;
          st_nx     = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (acnt != AQ_LAST) acnt_nx = acnt + QW'(1);
        if (acnt == AQ_LAST && period_ok) begin
          st_nx     = ST_PULSE;
          tcnt_nx   = '0;
          seen_nx   = 1'b0;
          start_evt = 1'b1;
        end
      end
      ST_PULSE: begin
        tcnt_nx = tcnt + TW'(1);
        if (eoc_s) seen_nx = 1'b1;
        if (tcnt == SW_LAST) st_nx = ST_CONV;
      end
      ST_CONV: begin
        if (tcnt != TMO_LAST) tcnt_nx = tcnt + TW'(1);
        if (eoc_s) seen_nx = 1'b1;
        if (seen && !eoc_s) begin
          st_nx   = ST_CAPT;
          ocnt_nx = '0;
        end else if (tcnt == TMO_LAST) begin
          err_nx = 1'b1;
          st_nx  = ST_ADV;
        end
      end
      ST_CAPT: begin
        ocnt_nx = ocnt + OW'(1);
        if (ocnt == OE_LAST) begin
          cap_en = 1'b1;
          st_nx  = ST_PUSH;
        end
      end
      ST_PUSH: begin
        if (s_ready) st_nx = ST_ADV;
      end
      ST_ADV: begin
        acnt_nx = '0;
        if (next_ok && (scan_single || run)) begin
          addr_nx = next_ch;
          st_nx   = ST_SETTLE;
        end else if (!scan_single && run && first_ok) begin
          addr_nx = first_ch;
          st_nx   = ST_SETTLE;
        end else begin
          st_nx = ST_IDLE;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st          <= ST_IDLE;
      adc_addr    <= '0;
      scan_single <= 1'b0;
      run_q       <= 1'b0;
      acnt        <= '0;
      tcnt        <= '0;
      ocnt        <= '0;
      seen        <= 1'b0;
      adc_start   <= 1'b0;
      adc_oe_n    <= 1'b1;
      s_valid     <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      st          <= st_nx;
      adc_addr    <= addr_nx;
      scan_single <= single_nx;
      run_q       <= run;
      acnt        <= acnt_nx;
      tcnt        <= tcnt_nx;
      ocnt        <= ocnt_nx;
      seen        <= seen_nx;
      adc_start   <= (st_nx == ST_PULSE);
      adc_oe_n    <= (st_nx != ST_CAPT);
      s_valid     <= (st_nx == ST_PUSH);
      err_timeout <= err_nx;
    end
  end

  // sample holding registers, clock-enabled on capture
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      s_data <= '0;
      s_chan <= '0;
    end else if (cap_en) begin
      s_data <= cap_word;
      s_chan <= adc_addr;
    end
  end

  // checker: measured length of each start pulse
  logic [15:0] hi_len;
  always_ff @(posedge clk or negedge rst_i)
    if (!rst_i)         hi_len <= '0;
    else if (adc_start) hi_len <= hi_len + 16'd1;
    else                hi_len <= '0;

  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(adc_start) |-> hi_len == 16'(START_W));

  assert_oe_after_eoc_R5: assert property (@(posedge clk) disable iff (!rst_i)
    !adc_oe_n |-> !eoc_s);

  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_i)
    !$stable(adc_addr) |-> ($past(st) == ST_ADV || $past(st) == ST_IDLE));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_i)
    s_valid && !s_ready |=> s_valid && $stable(s_data) && $stable(s_chan));

  assert_no_start_pending_R8: assert property (@(posedge clk) disable iff (!rst_i)
    s_valid |-> !adc_start && adc_oe_n);

  assert_err_single_R10: assert property (@(posedge clk) disable iff (!rst_i)
    err_timeout |=> !err_timeout);
endmodule

// File: tb/sim_adc_scan_seq.sv
module sim_adc_scan_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0, single = 1'b1, diff_mode = 1'b0, comp_code = 1'b0;
  logic [7:0]  ch_mask = 8'h00;
  logic [2:0]  gain_sel = 3'd0;
  logic [2:0]  adc_addr;
  logic        adc_start, adc_oe_n, err_timeout, s_valid;
  logic        s_ready = 1'b1;
  logic        stub_eoc = 1'b0;
  logic [11:0] stub_word = 12'h000;
  logic [11:0] adc_bus, s_data;
  logic [2:0]  s_chan;

  always #5 clk = ~clk;

  assign adc_bus = adc_oe_n ? 12'hA5A : stub_word;

  adc_scan_seq u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .single(single), .ch_mask(ch_mask),
    .gain_sel(gain_sel), .diff_mode(diff_mode), .comp_code(comp_code),
    .adc_addr(adc_addr), .adc_start(adc_start), .adc_eoc(stub_eoc),
    .adc_oe_n(adc_oe_n), .adc_bus(adc_bus), .err_timeout(err_timeout),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_chan(s_chan)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0, start_cnt = 0, err_cnt = 0, rx_n = 0;
  int conv_len = 60, stub_t = 0, exp_per = 0, last_rise = 0, rise_at = 0, oe_low = 0;
  bit stub_busy = 0, per_chk = 0, have_rise = 0, prev_start = 0, prev_oe = 1;
  logic [11:0] seed = 12'h000;
  logic [2:0]  rx_chan [64];
  logic [11:0] rx_data [64];
  logic [2:0]  ex_chan [8];
  int          ex_n;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int period_of(input logic [2:0] g);
    case (g)
      3'd0: return 250;
      3'd1: return 308;
      3'd2: return 364;
      3'd3: return 445;
      3'd4: return 572;
      default: return 2500;
    endcase
  endfunction

  // converter stub and port monitors, all on the falling edge
  always @(negedge clk) begin
    logic [11:0] tv;
    cyc++;
    if (adc_start && !prev_start) begin
      start_cnt++;
      if (per_chk && have_rise) chk(cyc - last_rise == exp_per, "R4", cyc - last_rise, exp_per);
      last_rise = cyc; rise_at = cyc; have_rise = 1;
      tv = seed ^ {4{adc_addr}};
      stub_word = comp_code ? ~tv : tv;
      stub_busy = 1; stub_t = 0;
    end
    if (!adc_start && prev_start) chk(cyc - rise_at == 10, "R3", cyc - rise_at, 10);
    prev_start = adc_start;
    if (stub_busy) begin
      stub_t++;
      stub_eoc = (stub_t >= 2) && (stub_t < 2 + conv_len);
      if (stub_t >= 2 + conv_len) stub_busy = 0;
    end
    if (!adc_oe_n && prev_oe) begin
      chk(!stub_eoc, "R5", stub_eoc, 0);
      oe_low = 0;
    end
    if (!adc_oe_n) oe_low++;
    if (adc_oe_n && !prev_oe) chk(oe_low == 2, "R5", oe_low, 2);
    prev_oe = adc_oe_n;
    if (err_timeout) err_cnt++;
    if (s_valid && s_ready && rx_n < 64) begin
      rx_chan[rx_n] = s_chan;
      rx_data[rx_n] = s_data;
      rx_n++;
    end
  end

  task automatic wait_rx(input int n, input int lim);
    int k = 0;
    while (rx_n < n && k < lim) begin @(negedge clk); k++; end
    if (rx_n < n) chk(0, "R2 sample count", rx_n, n);
  endtask

  task automatic launch();
    @(negedge clk); run = 1'b1;
    repeat (2) @(negedge clk);
    if (single) run = 1'b0;
  endtask

  localparam logic [24:0] VEC [8] = '{
    {8'hFF, 3'd0, 1'b0, 1'b0, 12'h123},
    {8'hA5, 3'd1, 1'b1, 1'b0, 12'hF0F},
    {8'h01, 3'd2, 1'b0, 1'b0, 12'h7E1},
    {8'h80, 3'd3, 1'b1, 1'b0, 12'h800},
    {8'hF3, 3'd0, 1'b0, 1'b1, 12'h555},
    {8'h5A, 3'd4, 1'b0, 1'b1, 12'h3C3},
    {8'h3C, 3'd5, 1'b1, 1'b0, 12'h0FF},
    {8'h42, 3'd7, 1'b0, 1'b0, 12'hABC}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int sc;
    logic [11:0] held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!adc_start, "R1 start", adc_start, 0);
    chk(adc_oe_n, "R1 oe_n", adc_oe_n, 1);
    chk(!s_valid && !err_timeout, "R1 valid/err", {s_valid, err_timeout}, 0);
    chk(adc_addr == 3'd0, "R1 addr", adc_addr, 0);

    // table of single-scan vectors: R2 order/tag, R4 pacing, R6 coding, R9 one pass
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      {ch_mask, gain_sel, comp_code, diff_mode, seed} = VEC[v];
      single = 1'b1;
      ex_n = 0;
      for (int c = 0; c < 8; c++)
        if (ch_mask[c] && (!diff_mode || c < 4)) begin ex_chan[ex_n] = 3'(c); ex_n++; end
      rx_n = 0; have_rise = 0; per_chk = 1; exp_per = period_of(gain_sel);
      sc = start_cnt;
      launch();
      wait_rx(ex_n, 25000);
      for (int i = 0; i < ex_n; i++) begin
        chk(rx_chan[i] == ex_chan[i], "R2 channel order", rx_chan[i], ex_chan[i]);
        chk(rx_data[i] == (seed ^ {4{ex_chan[i]}}), "R6 coding", rx_data[i], seed ^ {4{ex_chan[i]}});
      end
      repeat (3000) @(negedge clk);
      chk(start_cnt - sc == ex_n, "R9 single pass", start_cnt - sc, ex_n);
      per_chk = 0;
    end

    // R11 empty mask, plain and after differential restriction
    ch_mask = 8'h00; diff_mode = 1'b0; sc = start_cnt;
    launch(); repeat (500) @(negedge clk);
    chk(start_cnt == sc, "R11 empty mask", start_cnt - sc, 0);
    ch_mask = 8'hF0; diff_mode = 1'b1;
    launch(); repeat (500) @(negedge clk);
    chk(start_cnt == sc, "R11 R2 diff upper ignored", start_cnt - sc, 0);
    diff_mode = 1'b0;

    // R8 back-pressure across several periods
    ch_mask = 8'h03; gain_sel = 3'd0; comp_code = 1'b0; seed = 12'h9A1;
    s_ready = 1'b0; rx_n = 0;
    launch();
    for (int k = 0; k < 2000 && !s_valid; k++) @(negedge clk);
    held = s_data; sc = start_cnt;
    repeat (600) @(negedge clk);
    chk(s_valid, "R8 valid held", s_valid, 1);
    chk(s_data == held, "R8 data held", s_data, held);
    chk(start_cnt == sc, "R8 no start while stalled", start_cnt - sc, 0);
    @(negedge clk); s_ready = 1'b1;
    wait_rx(2, 3000);
    chk(rx_chan[0] == 3'd0 && rx_chan[1] == 3'd1, "R8 order after stall", {rx_chan[0], rx_chan[1]}, 6'o01);
    chk(rx_data[1] == (12'h9A1 ^ {4{3'd1}}), "R8 second sample", rx_data[1], 12'h9A1 ^ {4{3'd1}});
    repeat (500) @(negedge clk);

    // R9 continuous wrap then stop on run low
    ch_mask = 8'h81; single = 1'b0; seed = 12'h246; rx_n = 0;
    have_rise = 0; per_chk = 1; exp_per = 250;
    launch();
    wait_rx(4, 5000);
    per_chk = 0;
    @(negedge clk); run = 1'b0;
    for (int i = 0; i < 4; i++)
      chk(rx_chan[i] == ((i % 2 == 0) ? 3'd0 : 3'd7), "R9 wrap order", rx_chan[i], (i % 2 == 0) ? 0 : 7);
    repeat (2000) @(negedge clk);
    sc = start_cnt;
    repeat (2000) @(negedge clk);
    chk(start_cnt == sc, "R9 stop on run low", start_cnt - sc, 0);
    single = 1'b1;

    // R10 stuck converter on two channels
    conv_len = 500; ch_mask = 8'h06; rx_n = 0; err_cnt = 0;
    launch();
    repeat (1500) @(negedge clk);
    chk(err_cnt == 2, "R10 timeout pulses", err_cnt, 2);
    chk(rx_n == 0, "R10 no sample", rx_n, 0);
    conv_len = 60;
    repeat (800) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule